// File: doc/BRIEF.md
# Fail-Safe Main Clock Source Supervisor

This block picks the source of the main system clock from three candidates: an internal RC oscillator, a primary crystal oscillator, and an optional secondary high-frequency oscillator. The primary oscillator runs in either a low-frequency or a high-frequency mode. Software sets a 2-bit select code, the primary mode and the secondary enable through a single configuration write strobe.

A supervisor watches every oscillator that runs in a high-frequency role. Each one is resynchronised into the system clock domain, and its edges are counted against a free-running sample tick of about 1 MHz. When 100 consecutive sample periods pass with no edge, a sticky fault flag is raised. The same flag is raised when software switches off an oscillator that is being watched. While the flag is up, the main clock is forced back to the RC oscillator, whatever select code is stored. Software clears the flag with a one-cycle strobe. A crystal selection takes effect only once the flag is clear.

Reset places the primary oscillator in low-frequency mode, switches the secondary off, and leaves the flag set. A crystal that starts late, or never, therefore cannot be selected silently. Oscillator activity arrives as plain toggle inputs. The main clock output is a simple multiplexer that follows the registered source code.

Top module: `clk_supervisor`

## Requirements
- R1: After reset, `main_src` is 0 (RC), `fault_flag` is 1, `fault_irq` is 0, the primary is in low-frequency mode and the secondary is disabled.
- R2: With the flag clear, a stored select code of 3 gives `main_src`=3 (primary), code 2 gives 2 (secondary), and codes 0 and 1 give 0 (RC). The output settles within two clocks of the configuration write.
- R3: While `fault_flag` is 1, `main_src` is 0 from the next clock on, whatever the select code.
- R4: A supervised oscillator that shows no edge for 100 consecutive sample ticks sets the flag. The count is 101 ticks if an edge fell in the period that was in progress when the oscillator stopped. After 99 ticks the flag is still clear.
- R5: The primary is supervised only in high-frequency mode (`cfg_pri_hf`=1), and the secondary only while `cfg_sec_en`=1. An oscillator outside these cases never raises the flag, however long it is stopped.
- R6: A configuration write that changes `cfg_pri_hf` from 1 to 0, or `cfg_sec_en` from 1 to 0, sets the flag on that clock edge.
- R7: The flag stays set until a `flt_clr` strobe. If a set cause and the clear strobe occur in the same cycle, the flag ends up set. If the oscillator is still dead after a clear, the flag sets again within 100 further sample ticks.
- R8: `fault_irq` pulses high for exactly one clock each time the flag goes from 0 to 1, and never on a clear.
- R9: `main_clk` equals `rc_osc`, `pri_osc` or `sec_osc` when `main_src` is 0, 3 or 2 respectively.
- R10: Each detected edge of a supervised oscillator restarts its missed-sample count, so an oscillator that keeps toggling never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle pulse per sample period (~1 MHz) |
| rc_osc | input | 1 | Internal RC oscillator |
| pri_osc | input | 1 | Primary crystal oscillator toggle |
| sec_osc | input | 1 | Secondary high-frequency oscillator toggle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Requested source code (0/1 RC, 2 secondary, 3 primary) |
| cfg_pri_hf | input | 1 | Primary high-frequency mode |
| cfg_sec_en | input | 1 | Secondary oscillator enable |
| flt_clr | input | 1 | Write-one-to-clear strobe for the fault flag |
| main_clk | output | 1 | Selected main clock |
| main_src | output | 2 | Source in use (0 RC, 2 secondary, 3 primary) |
| fault_flag | output | 1 | Sticky oscillator fault flag |
| fault_irq | output | 1 | One-cycle pulse when the flag rises |

## Verification
The hardest situation to reach is a clear strobe that lands in the very cycle a fault cause appears. The missed-sample timeout cannot be aligned to a chosen clock from outside. The bench therefore uses the disable path, which acts within the same cycle: it drops the secondary enable and pulses the clear in one clock. The exact 100-tick boundary is reached in a similar way. The bench switches a dead primary into high-frequency mode, so the count starts from a known zero, and then checks the flag after 99 ticks and after the 100th.

// File: rtl/clksup_pkg.sv
package clksup_pkg;

    typedef enum logic [1:0] {
        SRC_RC  = 2'd0,
        SRC_ALT = 2'd1,
        SRC_SEC = 2'd2,
        SRC_PRI = 2'd3
    } src_e;

    typedef struct packed {
        logic [1:0] sel;
        logic       pri_hf;
        logic       sec_en;
    } cfg_t;

    localparam int NUM_OSC = 2;
    localparam int CH_PRI  = 0;
    localparam int CH_SEC  = 1;

    localparam cfg_t CFG_RESET = '{sel: 2'd0, pri_hf: 1'b0, sec_en: 1'b0};

    function automatic src_e pick_src(input logic fault, input logic [1:0] sel);
        src_e s;
        if (fault) begin
            s = SRC_RC;
        end else begin
            case (sel)
                2'd2:    s = SRC_SEC;
                2'd3:    s = SRC_PRI;
                default: s = SRC_RC;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/clksup_cfg.sv
module clksup_cfg
    import clksup_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  cfg_t               wr_data,
    output cfg_t               cfg_q,
    output logic [NUM_OSC-1:0] supervise,
    output logic               dis_evt
);
    cfg_t cfg_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= CFG_RESET;
        end else if (wr) begin
            cfg_r <= wr_data;
        end
    end

    // Switching off a watched oscillator is itself a fault cause.
    always_comb begin
        dis_evt = wr && ((cfg_r.pri_hf && !wr_data.pri_hf) ||
                         (cfg_r.sec_en && !wr_data.sec_en));
    end

    always_comb begin
        supervise         = '0;
        supervise[CH_PRI] = cfg_r.pri_hf;
        supervise[CH_SEC] = cfg_r.sec_en;
    end

    assign cfg_q = cfg_r;

    // R1: reset leaves primary in low-frequency mode and secondary off
    a_r1_reset_cfg: assert property (@(posedge clk)
        $past(rst) |-> (!cfg_r.pri_hf && !cfg_r.sec_en))
        else $error("a_r1_reset_cfg");

endmodule

// File: rtl/clksup_mon.sv
module clksup_mon #(
    parameter int MISS_LIMIT  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_tick,
    input  logic supervise,
    input  logic osc_in,
    output logic miss_hit
);
    localparam int CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);

    logic [SYNC_STAGES:0] sync_sh;
    logic                 edge_det;
    logic                 seen;
    logic [CW-1:0]        miss_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_sh <= '0;
        end else begin
            sync_sh <= {sync_sh[SYNC_STAGES-1:0], osc_in};
        end
    end

    assign edge_det = sync_sh[SYNC_STAGES] ^ sync_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_cnt <= '0;
            seen     <= 1'b0;
            miss_hit <= 1'b0;
        end else begin
            miss_hit <= 1'b0;
            if (!supervise) begin
                miss_cnt <= '0;
                seen     <= 1'b0;
            end else if (sample_tick) begin
                seen <= 1'b0;
                if (seen || edge_det) begin
                    miss_cnt <= '0;
                end else if (miss_cnt == LAST) begin
                    miss_cnt <= '0;
                    miss_hit <= 1'b1;
                end else begin
                    miss_cnt <= miss_cnt + 1'b1;
                end
            end else if (edge_det) begin
                miss_cnt <= '0;
                seen     <= 1'b1;
            end
        end
    end

    // R4: count never reaches the limit value itself
    a_r4_miss_bounded: assert property (@(posedge clk) disable iff (rst)
        miss_cnt < CW'(MISS_LIMIT))
        else $error("a_r4_miss_bounded");

    // R5: an unsupervised oscillator holds no count and raises nothing
    a_r5_idle_unsupervised: assert property (@(posedge clk) disable iff (rst)
        !supervise |=> (miss_cnt == '0 && !miss_hit))
        else $error("a_r5_idle_unsupervised");

    // R10: a detected edge restarts the count
    a_r10_edge_restarts: assert property (@(posedge clk) disable iff (rst)
        (supervise && edge_det) |=> (miss_cnt == '0 && !miss_hit))
        else $error("a_r10_edge_restarts");

endmodule

// File: rtl/clksup_flag.sv
module clksup_flag
    import clksup_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] miss_hit,
    input  logic               dis_evt,
    input  logic               flt_clr,
    output logic               fault_flag,
    output logic               fault_irq
);
    logic set_req;

    assign set_req = (|miss_hit) || dis_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_flag <= 1'b1;
            fault_irq  <= 1'b0;
        end else begin
            fault_irq <= set_req && !fault_flag;
            if (set_req) begin
                fault_flag <= 1'b1;
            end else if (flt_clr) begin
                fault_flag <= 1'b0;
            end
        end
    end

    // R8: interrupt only on a rising flag
    a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
        fault_irq |-> (fault_flag && !$past(fault_flag)))
        else $error("a_r8_irq_on_rise");

    // R7: flag is sticky without a clear strobe
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !flt_clr) |=> fault_flag)
        else $error("a_r7_sticky");

    // R7: set beats a simultaneous clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_req && flt_clr) |=> fault_flag)
        else $error("a_r7_set_wins");

endmodule

// File: rtl/clksup_sel.sv
module clksup_sel
    import clksup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fault_flag,
    input  logic [1:0] sel,
    input  logic       rc_osc,
    input  logic       pri_osc,
    input  logic       sec_osc,
    output src_e       main_src,
    output logic       main_clk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            main_src <= SRC_RC;
        end else begin
            main_src <= pick_src(fault_flag, sel);
        end
    end

    always_comb begin
        case (main_src)
            SRC_PRI: main_clk = pri_osc;
            SRC_SEC: main_clk = sec_osc;
            default: main_clk = rc_osc;
        endcase
    end

    // R3: a set flag forces the RC source on the next clock
    a_r3_fault_forces_rc: assert property (@(posedge clk) disable iff (rst)
        fault_flag |=> (main_src == SRC_RC))
        else $error("a_r3_fault_forces_rc");

    // R2: codes 0 and 1 never reach a crystal
    a_r2_low_codes_rc: assert property (@(posedge clk) disable iff (rst)
        (sel[1] == 1'b0) |=> (main_src == SRC_RC))
        else $error("a_r2_low_codes_rc");

endmodule

// File: rtl/clk_supervisor.sv
module clk_supervisor
    import clksup_pkg::*;
#(
    parameter int MISS_LIMIT  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_tick,
    input  logic       rc_osc,
    input  logic       pri_osc,
    input  logic       sec_osc,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_pri_hf,
    input  logic       cfg_sec_en,
    input  logic       flt_clr,
    output logic       main_clk,
    output logic [1:0] main_src,
    output logic       fault_flag,
    output logic       fault_irq
);
    cfg_t               wr_data;
    cfg_t               cfg_q;
    logic [NUM_OSC-1:0] supervise;
    logic [NUM_OSC-1:0] osc_vec;
    logic [NUM_OSC-1:0] miss_hit;
    logic               dis_evt;
    src_e               src_q;

    assign wr_data = '{sel: cfg_sel, pri_hf: cfg_pri_hf, sec_en: cfg_sec_en};

    always_comb begin
        osc_vec         = '0;
        osc_vec[CH_PRI] = pri_osc;
        osc_vec[CH_SEC] = sec_osc;
    end

    clksup_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .wr_data   (wr_data),
        .cfg_q     (cfg_q),
        .supervise (supervise),
        .dis_evt   (dis_evt)
    );

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_mon
        clksup_mon #(
            .MISS_LIMIT  (MISS_LIMIT),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_mon (
            .clk         (clk),
            .rst         (rst),
            .sample_tick (sample_tick),
            .supervise   (supervise[g]),
            .osc_in      (osc_vec[g]),
            .miss_hit    (miss_hit[g])
        );
    end

    clksup_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .miss_hit   (miss_hit),
        .dis_evt    (dis_evt),
        .flt_clr    (flt_clr),
        .fault_flag (fault_flag),
        .fault_irq  (fault_irq)
    );

    clksup_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .fault_flag (fault_flag),
        .sel        (cfg_q.sel),
        .rc_osc     (rc_osc),
        .pri_osc    (pri_osc),
        .sec_osc    (sec_osc),
        .main_src   (src_q),
        .main_clk   (main_clk)
    );

    assign main_src = src_q;

    // R1: state directly after reset
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (fault_flag && !fault_irq && main_src == 2'd0))
        else $error("a_r1_reset_state");

endmodule

// File: tb/clk_supervisor_bench.sv
module clk_supervisor_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       rc_osc = 1'b0;
    logic       pri_osc = 1'b0;
    logic       sec_osc = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic       cfg_pri_hf = 1'b0;
    logic       cfg_sec_en = 1'b0;
    logic       flt_clr = 1'b0;
    logic       main_clk;
    logic [1:0] main_src;
    logic       fault_flag;
    logic       fault_irq;

    int  checks = 0;
    int  errors = 0;
    int  irq_cnt = 0;
    bit  pri_run = 1'b0;
    bit  sec_run = 1'b0;
    bit  done = 1'b0;
    int  osc_div = 0;
    logic [1:0] cur_sel = 2'd0;

    always #4 clk = ~clk;

    clk_supervisor u_clk_supervisor (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .rc_osc      (rc_osc),
        .pri_osc     (pri_osc),
        .sec_osc     (sec_osc),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_pri_hf  (cfg_pri_hf),
        .cfg_sec_en  (cfg_sec_en),
        .flt_clr     (flt_clr),
        .main_clk    (main_clk),
        .main_src    (main_src),
        .fault_flag  (fault_flag),
        .fault_irq   (fault_irq)
    );

    // oscillator models, toggled away from the active edge
    always @(negedge clk) begin
        rc_osc  <= ~rc_osc;
        osc_div <= osc_div + 1;
        if (osc_div[0]) begin
            if (pri_run) pri_osc <= ~pri_osc;
            if (sec_run) sec_osc <= ~sec_osc;
        end
    end

    always @(negedge clk) begin
        if (fault_irq) irq_cnt <= irq_cnt + 1;
    end

    function automatic logic [1:0] exp_src(input logic flag, input logic [1:0] sel);
        if (flag) return 2'd0;
        if (sel == 2'd2) return 2'd2;
        if (sel == 2'd3) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic exp_clk(input logic [1:0] src);
        if (src == 2'd3) return pri_osc;
        if (src == 2'd2) return sec_osc;
        return rc_osc;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic hf, input logic en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_pri_hf = hf; cfg_sec_en = en;
        cur_sel = sel;
        @(negedge clk);
        cfg_wr = 1'b0;
        settle(3);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0;
        settle(3);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            sample_tick = 1'b1;
            @(negedge clk);
            sample_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        settle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int irq_before;
        void'($urandom(32'h00C1_0C5A));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle(1);
        // R1: reset state
        chk("R1 src", main_src, 0);
        chk("R1 flag", fault_flag, 1);
        chk("R1 irq", fault_irq, 0);

        // R3: crystal requested while flag set stays on RC
        cfg_write(2'd3, 1'b0, 1'b0);
        chk("R3 forced rc", main_src, 0);

        // R2/R5: primary in LF mode, stopped, unsupervised
        clear_flag();
        chk("R2 primary", main_src, 3);
        chk("R9 clk primary", main_clk, exp_clk(2'd3));
        ticks(300);
        chk("R5 lf unsupervised", fault_flag, 0);
        chk("R5 no irq", irq_cnt, 0);

        // R2/R10: secondary enabled and running
        sec_run = 1'b1;
        cfg_write(2'd2, 1'b0, 1'b1);
        chk("R2 secondary", main_src, 2);
        ticks(200);
        chk("R10 running no fault", fault_flag, 0);
        chk("R9 clk secondary", main_clk, exp_clk(2'd2));

        // R4: secondary stops
        sec_run = 1'b0;
        settle(6);
        irq_before = irq_cnt;
        ticks(99);
        chk("R4 not before 100", fault_flag, 0);
        ticks(2);
        chk("R4 fault by 101", fault_flag, 1);
        chk("R3 fallback rc", main_src, 0);
        chk("R8 one irq", irq_cnt, irq_before + 1);

        // R7: clear with dead oscillator, sets again
        irq_before = irq_cnt;
        clear_flag();
        chk("R7 cleared", fault_flag, 0);
        chk("R8 no irq on clear", irq_cnt, irq_before);
        ticks(101);
        chk("R7 re-fault", fault_flag, 1);

        // R7: recovery after restart and clear
        sec_run = 1'b1;
        settle(6);
        clear_flag();
        ticks(200);
        chk("R7 recovered flag", fault_flag, 0);
        chk("R7 recovered src", main_src, 2);

        // R6: disabling the supervised secondary
        cfg_write(2'd2, 1'b0, 1'b0);
        chk("R6 sec disable", fault_flag, 1);
        chk("R6 sec src", main_src, 0);

        // R6: leaving HF mode on the primary
        pri_run = 1'b1;
        clear_flag();
        cfg_write(2'd3, 1'b1, 1'b0);
        chk("R2 primary hf", main_src, 3);
        cfg_write(2'd3, 1'b0, 1'b0);
        chk("R6 hf off", fault_flag, 1);

        // R7: set cause and clear in the same cycle
        clear_flag();
        cfg_write(2'd3, 1'b1, 1'b1);
        chk("R7 pre clear", fault_flag, 0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sec_en = 1'b0; flt_clr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; flt_clr = 1'b0;
        settle(2);
        chk("R7 set wins", fault_flag, 1);

        // random selection with both crystals healthy
        cfg_write(2'd0, 1'b1, 1'b1);
        clear_flag();
        for (int i = 0; i < 40; i++) begin
            logic [1:0] s;
            s = 2'($urandom % 4);
            cfg_write(s, 1'b1, 1'b1);
            if (($urandom % 4) == 0) clear_flag();
            chk("R2 random src", main_src, exp_src(1'b0, s));
            chk("R9 random clk", main_clk, exp_clk(exp_src(1'b0, s)));
        end
        ticks(20);
        chk("R10 both running", fault_flag, 0);

        // R4: switch a dead primary into HF mode, exact 100 boundary
        pri_run = 1'b0;
        cfg_write(2'd3, 1'b0, 1'b0);
        clear_flag();
        settle(6);
        cfg_write(2'd3, 1'b1, 1'b0);
        chk("R4 pending start", fault_flag, 0);
        ticks(99);
        chk("R4 hf 99", fault_flag, 0);
        chk("R2 hf dead still primary", main_src, 3);
        ticks(1);
        chk("R4 hf 100", fault_flag, 1);
        chk("R3 hf fallback", main_src, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule